// File: doc/BRIEF.md
# Reset and Interrupt Vector Fetch Sequencer

This block sits beside the instruction sequencer of an 8-bit processor. When the chip leaves reset, when the non-maskable interrupt line rises, or when a maskable interrupt or software break is pending, it picks the matching two-byte vector in the top six bytes of the address space and reads it one byte at a time through the processor's memory read port. It then presents the assembled 16-bit value as the next program counter, with a one-cycle load strobe.

Memory is assumed synchronous with one cycle of read latency: the byte addressed while the read strobe is high is on the read data input during the following cycle. Pushing the return state onto the stack is done elsewhere, before this block is asked to run. Requests that appear while a fetch is in progress wait until it completes.

Top module: `vec_fetch_seq`

## Requirements
- R1: While rst_ni is low, rd_en_o and pc_load_o are 0; taking rst_ni low in the middle of a fetch drops rd_en_o at once.
- R2: After rst_ni is released, the first fetch reads 0xFFFC and then 0xFFFD and loads pc_o = {byte at 0xFFFD, byte at 0xFFFC}.
- R3: A rising edge on nmi_i starts one fetch of 0xFFFA (low byte) then 0xFFFB (high byte); holding nmi_i high afterwards causes no further fetch.
- R4: A maskable interrupt or a break reads 0xFFFE (low byte) then 0xFFFF (high byte), the same vector for both.
- R5: irq_i is ignored while irq_mask_i is 1; brk_i is never blocked by irq_mask_i.
- R6: irq_i is level-sensitive: while it stays high and unmasked, a new fetch begins in the cycle right after each PC load.
- R7: Priority among waiting requests is reset first, then the non-maskable interrupt, then break/maskable interrupt.
- R8: A fetch drives rd_en_o for exactly two consecutive cycles, low address first and low address + 1 next, begins in the cycle after the request is taken, and pulses pc_load_o for one cycle two cycles after the second read.
- R9: A rising edge on nmi_i that occurs while a fetch is in progress is held and served by the fetch that directly follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release starts the reset vector fetch |
| nmi_i | input | 1 | Non-maskable interrupt, acted on at its rising edge |
| irq_i | input | 1 | Maskable interrupt request, level-sensitive |
| brk_i | input | 1 | Software break request, level-sensitive |
| irq_mask_i | input | 1 | Interrupt-disable flag; 1 blocks irq_i |
| rd_data_i | input | DATA_W | Byte returned by memory one cycle after a read |
| rd_en_o | output | 1 | Read strobe |
| rd_addr_o | output | ADDR_W | Read address |
| pc_o | output | 2*DATA_W | Assembled vector, valid while pc_load_o is 1 |
| pc_load_o | output | 1 | One-cycle strobe to load pc_o into the program counter |

## Verification
The bench builds the block with its default widths, a 16-bit address and 8-bit data, which puts the three vectors at the real top-of-memory addresses 0xFFFA to 0xFFFF and lets a small modelled memory return distinct bytes for each of the six locations. With that, a swapped byte order, a wrong vector pair or a misordered priority shows up as a wrong program counter value. The exact cycle at which each strobe appears is checked, including back-to-back fetches under a held interrupt level and an edge arriving mid-fetch.

// File: rtl/vec_seq_pkg.sv
package vec_seq_pkg;
  typedef enum logic [1:0] {
    SRC_RESET = 2'd0,
    SRC_NMI   = 2'd1,
    SRC_IRQ   = 2'd2
  } vec_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } fetch_st_e;

  // distance of each vector's low byte below the top address
  localparam int unsigned VEC_OFS_NMI   = 5;
  localparam int unsigned VEC_OFS_RESET = 3;
  localparam int unsigned VEC_OFS_IRQ   = 1;
endpackage

// File: rtl/vec_nmi_latch.sv
module vec_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clear_i,
  output logic req_o
);
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise  = nmi_i & ~prev_q;
  assign req_o = pend_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_i;
      pend_q <= (pend_q | rise) & ~clear_i;
    end
  end

  // R3
  edge_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nmi_i) && !clear_i) |=> pend_q);

  // R3
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !$rose(nmi_i)) |=> !pend_q);
endmodule

// File: rtl/vec_arbiter.sv
module vec_arbiter
  import vec_seq_pkg::*;
(
  input  logic     rst_pend_i,
  input  logic     nmi_req_i,
  input  logic     irq_i,
  input  logic     brk_i,
  input  logic     irq_mask_i,
  output logic     req_o,
  output vec_src_e src_o
);
  logic irq_live;

  assign irq_live = brk_i | (irq_i & ~irq_mask_i);

  always_comb begin
    req_o = rst_pend_i | nmi_req_i | irq_live;
    if (rst_pend_i)     src_o = SRC_RESET;
    else if (nmi_req_i) src_o = SRC_NMI;
    else                src_o = SRC_IRQ;
  end
endmodule

// File: rtl/vec_fetch_fsm.sv
module vec_fetch_fsm
  import vec_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  vec_src_e            src_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                accept_o,
  output logic                rst_pend_o,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic                pc_load_o
);
  localparam int unsigned PC_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] VEC_TOP = {ADDR_W{1'b1}};

  fetch_st_e           state_q;
  vec_src_e            src_q;
  logic [DATA_W-1:0]   lo_q;
  logic [PC_W-1:0]     pc_q;
  logic                load_q;
  logic                rst_pend_q;
  logic [ADDR_W-1:0]   vec_lo;

  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign rst_pend_o = rst_pend_q;

  always_comb begin
    case (src_q)
      SRC_RESET: vec_lo = VEC_TOP - ADDR_W'(VEC_OFS_RESET);
      SRC_NMI:   vec_lo = VEC_TOP - ADDR_W'(VEC_OFS_NMI);
      default:   vec_lo = VEC_TOP - ADDR_W'(VEC_OFS_IRQ);
    endcase
  end

  assign rd_en_o   = (state_q == ST_LO) || (state_q == ST_HI);
  assign rd_addr_o = (state_q == ST_HI) ? vec_lo + 1'b1 : vec_lo;
  assign pc_o      = pc_q;
  assign pc_load_o = load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      src_q      <= SRC_RESET;
      lo_q       <= '0;
      pc_q       <= '0;
      load_q     <= 1'b0;
      rst_pend_q <= 1'b1;
    end else begin
      load_q <= (state_q == ST_DONE);
      case (state_q)
        ST_IDLE: if (req_i) begin
          src_q   <= src_i;
          state_q <= ST_LO;
          if (src_i == SRC_RESET) rst_pend_q <= 1'b0;
        end
        ST_LO: state_q <= ST_HI;
        ST_HI: begin
          lo_q    <= rd_data_i;  // data of the low-byte read
          state_q <= ST_DONE;
        end
        default: begin
          pc_q    <= {rd_data_i, lo_q};
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R8
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LO) |=> (rd_en_o && rd_addr_o == $past(rd_addr_o) + 1'b1));

  // R8
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);

  // R8
  read_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_en_o) && rd_en_o) |=> !rd_en_o);

  // R2
  reset_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pend_q && req_i && state_q == ST_IDLE) |=>
      (rd_addr_o == VEC_TOP - ADDR_W'(VEC_OFS_RESET)));
endmodule

// File: rtl/vec_fetch_seq.sv
module vec_fetch_seq
  import vec_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nmi_i,
  input  logic                irq_i,
  input  logic                brk_i,
  input  logic                irq_mask_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic                pc_load_o
);
  logic     nmi_req;
  logic     rst_pend;
  logic     req;
  logic     accept;
  vec_src_e src;

  vec_nmi_latch u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .clear_i (accept && src == SRC_NMI),
    .req_o   (nmi_req)
  );

  vec_arbiter u_arb (
    .rst_pend_i (rst_pend),
    .nmi_req_i  (nmi_req),
    .irq_i      (irq_i),
    .brk_i      (brk_i),
    .irq_mask_i (irq_mask_i),
    .req_o      (req),
    .src_o      (src)
  );

  vec_fetch_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .src_i      (src),
    .rd_data_i  (rd_data_i),
    .accept_o   (accept),
    .rst_pend_o (rst_pend),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .pc_o       (pc_o),
    .pc_load_o  (pc_load_o)
  );

  // R7
  nmi_over_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req && !rst_pend) |-> (src == SRC_NMI));

  // R5
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && src == SRC_IRQ) |-> (brk_i || !irq_mask_i));

  // R6
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o && irq_i && !irq_mask_i) |=> rd_en_o);
endmodule

// File: tb/vec_fetch_seq_test.sv
module vec_fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nmi_i = 1'b0, irq_i = 1'b0, brk_i = 1'b0, irq_mask_i = 1'b0;
  logic [7:0]  rd_data_i = 8'h00;
  logic        rd_en_o, pc_load_o;
  logic [15:0] rd_addr_o, pc_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [15:0] PC_RST = 16'hC123, PC_NMI = 16'h8A47, PC_IRQ = 16'h3E9D;

  always #4 clk = ~clk;  // 125 MHz

  vec_fetch_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .nmi_i(nmi_i), .irq_i(irq_i), .brk_i(brk_i),
    .irq_mask_i(irq_mask_i), .rd_data_i(rd_data_i), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .pc_o(pc_o), .pc_load_o(pc_load_o)
  );

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    case (a)
      16'hFFFA: return PC_NMI[7:0];
      16'hFFFB: return PC_NMI[15:8];
      16'hFFFC: return PC_RST[7:0];
      16'hFFFD: return PC_RST[15:8];
      16'hFFFE: return PC_IRQ[7:0];
      16'hFFFF: return PC_IRQ[15:8];
      default:  return a[7:0] ^ 8'hA5;
    endcase
  endfunction

  always @(posedge clk) if (rd_en_o) rd_data_i <= mem_rd(rd_addr_o);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; follows one whole fetch, returns at the negedge of the load cycle
  task automatic run_fetch(input logic [15:0] lo, input logic [15:0] pc_exp,
                           input string req, input int max_wait, input bit inject_nmi,
                           output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!rd_en_o && waited < max_wait);
    chk(rd_en_o, req, "read strobe seen", rd_en_o, 1);
    chk(rd_addr_o == lo, req, "low byte address", rd_addr_o, lo);
    if (inject_nmi) begin nmi_i = 1'b1; irq_i = 1'b0; end
    @(negedge clk);
    if (inject_nmi) nmi_i = 1'b0;
    chk(rd_en_o && rd_addr_o == lo + 16'd1, "R8", "high byte read", rd_addr_o, lo + 16'd1);
    @(negedge clk);
    chk(!rd_en_o && !pc_load_o, "R8", "gap cycle idle", {rd_en_o, pc_load_o}, 0);
    @(negedge clk);
    chk(pc_load_o, "R8", "load strobe", pc_load_o, 1);
    chk(pc_o == pc_exp, req, "loaded pc", pc_o, pc_exp);
  endtask

  task automatic quiet(input int cycles, input string req, input string what);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rd_en_o || pc_load_o) seen = 1;
    end
    chk(!seen, req, what, seen, 0);
  endtask

  task automatic t_reset();
    int w;
    irq_i = 1'b1;  // pending irq must lose to reset (R7)
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rd_en_o && !pc_load_o, "R1", "idle in reset", {rd_en_o, pc_load_o}, 0);
    end
    rst_ni = 1'b1;
    run_fetch(16'hFFFC, PC_RST, "R2", 4, 0, w);
    chk(w == 1, "R8", "start delay after release", w, 1);
    run_fetch(16'hFFFE, PC_IRQ, "R6", 4, 0, w);
    chk(w == 1, "R6", "back-to-back level fetch", w, 1);
    irq_i = 1'b0;
    quiet(6, "R6", "no fetch after irq drops");
  endtask

  task automatic t_mask();
    int w;
    irq_mask_i = 1'b1; irq_i = 1'b1;
    quiet(12, "R5", "masked irq ignored");
    brk_i = 1'b1;
    run_fetch(16'hFFFE, PC_IRQ, "R5", 4, 0, w);
    brk_i = 1'b0;
    quiet(4, "R5", "masked irq after break");
    irq_mask_i = 1'b0;
    run_fetch(16'hFFFE, PC_IRQ, "R4", 4, 0, w);
    irq_i = 1'b0;
  endtask

  task automatic t_nmi();
    int w;
    nmi_i = 1'b1;
    run_fetch(16'hFFFA, PC_NMI, "R3", 4, 0, w);
    quiet(10, "R3", "held nmi serviced once");
    nmi_i = 1'b0;
    quiet(2, "R3", "nmi fall ignored");
  endtask

  task automatic t_prio();
    int w;
    nmi_i = 1'b1; irq_i = 1'b1;
    run_fetch(16'hFFFA, PC_NMI, "R7", 4, 0, w);
    run_fetch(16'hFFFE, PC_IRQ, "R7", 4, 0, w);
    chk(w == 1, "R7", "irq right after nmi", w, 1);
    irq_i = 1'b0; nmi_i = 1'b0;
    quiet(3, "R7", "quiet after pair");
  endtask

  task automatic t_busy();
    int w;
    irq_i = 1'b1;
    run_fetch(16'hFFFE, PC_IRQ, "R9", 4, 1, w);
    run_fetch(16'hFFFA, PC_NMI, "R9", 4, 0, w);
    chk(w == 1, "R9", "held edge served next", w, 1);
    quiet(3, "R9", "edge served once");
  endtask

  task automatic t_reset_mid();
    int w;
    irq_i = 1'b1;
    @(negedge clk);
    chk(rd_en_o, "R1", "fetch under way", rd_en_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(!rd_en_o && !pc_load_o, "R1", "reset aborts fetch", {rd_en_o, pc_load_o}, 0);
    irq_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    run_fetch(16'hFFFC, PC_RST, "R2", 4, 0, w);
    chk(w == 1, "R2", "refetch after reset", w, 1);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_nmi();
    t_prio();
    t_busy();
    t_reset_mid();
    quiet(2, "R1", "final idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule